// File: doc/BRIEF.md
# Bus Region Decoder with Per-Region Wait States

This block sits on the external bus of a 16-bit signal processor whose program, data and I/O spaces share one address bus. It receives an active-low strobe for each space, a read/write level and an active-low bus strobe. From these it drives one active-low chip select for each attached device: the boot monitor ROM, program RAM, external data RAM, a character display, a keyboard port, two converter channels and an output LED latch. It also drives the read and write enables for the memory side and for the I/O side.

A ready output holds the processor off for a wait count that depends on the region being accessed. A protection flag reports user-mode writes into the monitor's scratch window. When the remap option is enabled, program fetches from the low vector page are steered into program RAM.

The region map is fixed. Each region's wait count is a parameter. An access is one stretch of cycles in which the bus strobe is low. Address, space strobes and direction must stay stable during that stretch, and the strobe must go high for at least one cycle between accesses.

Top module: `bus_decode_ws`

## Requirements
- R1: In program space, addresses 0x0000 to 0xBFFF assert `rom_cs_n` and addresses 0xC000 to 0xFFFF assert `pram_cs_n`. This applies when remapping does not apply (see R8).
- R2: In data space, addresses 0x8000 to 0xFFFF assert `dram_cs_n`. Addresses 0x0000 to 0x7FFF are internal memory: they assert no select and complete with zero waits.
- R3: A data-space write (`rw`=0) to 0x8000 to 0x8FFF while `user_mode`=1 asserts no select. It completes with zero waits and raises `prot_err` in the first strobe cycle only. Reads of that window, and writes to it with `user_mode`=0, select the data RAM normally.
- R4: The I/O map, by full 16-bit address, selects as follows. A write to 0x0000 and a read from 0x0001 select the display. A read from 0x0002 selects the keyboard. Writes to 0x0004 and 0x0005 select converter channels 1 and 2. A write to 0x0006 selects the LED latch.
- R5: An I/O access to any other address, or with the direction not listed in R4, asserts no select and completes with zero waits.
- R6: Cycle 0 is the first cycle with `strb_n` low. `ready` first goes high in cycle W, where W is the region's wait count. With the default parameters, W is 2 for the ROM, program RAM and data RAM, 6 for the display, 1 for the keyboard, converters and LED latch, and 0 for everything else.
- R7: `ready` is high for exactly one cycle per access, even if `strb_n` is held low longer. It is low whenever `strb_n` is high.
- R8: With `remap_en`=1, a program-space access to 0x0000 to 0x003F selects program RAM with program RAM waits, and drives `mem_addr` = 0xC000 + address. Otherwise `mem_addr` equals `addr`.
- R9: `mem_rd_n` and `mem_wr_n` are low while the strobe is low, exactly one space strobe is low, and that strobe is the program or data strobe, with `rw`=1 and `rw`=0 respectively. `io_rd_n` and `io_wr_n` are formed the same way from the I/O strobe. Otherwise all four are high.
- R10: At most one select is low at any time. No select is low while `strb_n` is high. If no space strobe, or more than one, is low during an access, no select or enable is asserted and the access completes with zero waits.
- R11: After synchronous reset, with the strobe high, all selects and enables are high and `ready` and `prot_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Bus address |
| ps_n | input | 1 | Program-space strobe, active low |
| ds_n | input | 1 | Data-space strobe, active low |
| is_n | input | 1 | I/O-space strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| strb_n | input | 1 | Bus strobe, active low |
| user_mode | input | 1 | High while user code runs |
| remap_en | input | 1 | Enables vector page redirection |
| mem_addr | output | 16 | Address presented to memories |
| rom_cs_n | output | 1 | Monitor ROM select |
| pram_cs_n | output | 1 | Program RAM select |
| dram_cs_n | output | 1 | Data RAM select |
| lcd_cs_n | output | 1 | Display select |
| kbd_cs_n | output | 1 | Keyboard port select |
| dac1_cs_n | output | 1 | Converter channel 1 select |
| dac2_cs_n | output | 1 | Converter channel 2 select |
| led_cs_n | output | 1 | LED latch select |
| mem_rd_n | output | 1 | Memory read enable |
| mem_wr_n | output | 1 | Memory write enable |
| io_rd_n | output | 1 | I/O read enable |
| io_wr_n | output | 1 | I/O write enable |
| ready | output | 1 | Access completes in this cycle |
| prot_err | output | 1 | User write into monitor window |

## Verification
The hardest case to reach from the ports is an access that sits exactly on a region edge while the strobe stays low well past its wait count. Examples are a display access held for seven cycles, or a user write at 0x8FFF next to one at 0x9000. In such cases a second `ready` pulse or a lingering protection flag would only show after the count saturates. Every access holds the strobe low for nine cycles and counts the `ready` pulses. The random address generator draws most addresses from small windows around 0x003F/0x0040, 0x7FFF/0x8000, 0x8FFF/0x9000, 0xBFFF/0xC000 and the I/O codes 0 to 7, with direction, user mode and remap chosen at random. Directed accesses add the conflicting-strobe case and the remap window.

// File: rtl/memio_pkg.sv
package memio_pkg;

    typedef enum logic [3:0] {
        RG_NONE, RG_ONCHIP, RG_PROT, RG_ROM, RG_PRAM, RG_DRAM,
        RG_LCD, RG_KBD, RG_DAC1, RG_DAC2, RG_LED
    } region_e;

    typedef enum logic [1:0] {SP_NONE, SP_PROG, SP_DATA, SP_IO} space_e;

    typedef struct packed {
        region_e     region;
        logic [15:0] maddr;
    } decode_t;

    // select bundle, active high inside the block
    typedef struct packed {
        logic rom, pram, dram, lcd, kbd, dac1, dac2, led;
    } sel_t;

    localparam logic [15:0] PRAM_BASE  = 16'hC000;
    localparam logic [15:0] XRAM_BASE  = 16'h8000;
    localparam logic [15:0] MONBUF_END = 16'h8FFF;
    localparam logic [15:0] VEC_TOP    = 16'h003F;
    localparam logic [15:0] IO_LCD_WR  = 16'h0000;
    localparam logic [15:0] IO_LCD_RD  = 16'h0001;
    localparam logic [15:0] IO_KBD     = 16'h0002;
    localparam logic [15:0] IO_DAC1    = 16'h0004;
    localparam logic [15:0] IO_DAC2    = 16'h0005;
    localparam logic [15:0] IO_LED     = 16'h0006;

    function automatic space_e pick_space(input logic ps_n, input logic ds_n, input logic is_n);
        logic [1:0] cnt;
        cnt = 2'(!ps_n) + 2'(!ds_n) + 2'(!is_n);
        if (cnt != 2'd1) return SP_NONE;
        if (!ps_n) return SP_PROG;
        if (!ds_n) return SP_DATA;
        return SP_IO;
    endfunction

    function automatic int wmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/memio_space_decode.sv
module memio_space_decode
    import memio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  space_e      space,
    input  logic [15:0] addr,
    input  logic        rw,
    input  logic        user_mode,
    input  logic        remap_en,
    output decode_t     dec
);

    always_comb begin
        dec.region = RG_NONE;
        dec.maddr  = addr;
        case (space)
            SP_PROG: begin
                if (remap_en && addr <= VEC_TOP) begin
                    dec.region = RG_PRAM;
                    dec.maddr  = PRAM_BASE + addr;
                end else if (addr >= PRAM_BASE) begin
                    dec.region = RG_PRAM;
                end else begin
                    dec.region = RG_ROM;
                end
            end
            SP_DATA: begin
                if (addr < XRAM_BASE)
                    dec.region = RG_ONCHIP;
                else if (addr <= MONBUF_END && !rw && user_mode)
                    dec.region = RG_PROT;
                else
                    dec.region = RG_DRAM;
            end
            SP_IO: begin
                case (addr)
                    IO_LCD_WR: if (!rw) dec.region = RG_LCD;
                    IO_LCD_RD: if (rw)  dec.region = RG_LCD;
                    IO_KBD:    if (rw)  dec.region = RG_KBD;
                    IO_DAC1:   if (!rw) dec.region = RG_DAC1;
                    IO_DAC2:   if (!rw) dec.region = RG_DAC2;
                    IO_LED:    if (!rw) dec.region = RG_LED;
                    default:   dec.region = RG_NONE;
                endcase
            end
            default: dec.region = RG_NONE;
        endcase
    end

    // R3: the protected outcome only for user-mode data writes
    p_prot_user_write_r3: assert property (@(posedge clk) disable iff (rst)
        (dec.region == RG_PROT) |-> (!rw && user_mode && space == SP_DATA));

    // R8: vector page lands in program RAM only under remap
    p_remap_target_r8: assert property (@(posedge clk) disable iff (rst)
        (space == SP_PROG && addr <= VEC_TOP && dec.region == RG_PRAM)
            |-> (remap_en && dec.maddr[15:14] == 2'b11));

endmodule

// File: rtl/memio_wait_timer.sv
module memio_wait_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [CW-1:0] waits,
    output logic          ready,
    output logic          first_cycle
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (!active)
            cnt <= '0;
        else if (cnt <= waits)
            cnt <= cnt + 1'b1;
    end

    assign ready       = active && (cnt == waits);
    assign first_cycle = active && (cnt == '0);

    // R7: one ready cycle per access
    p_ready_single_r7: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R7: no ready without a strobe
    p_ready_needs_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        !active |-> !ready);

    // R6: a nonzero wait means the strobe was already low a cycle earlier
    p_wait_elapsed_r6: assert property (@(posedge clk) disable iff (rst)
        (ready && waits != '0) |-> $past(active));

endmodule

// File: rtl/memio_select_drive.sv
module memio_select_drive
    import memio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    active,
    input  region_e region,
    output sel_t    sel_n
);

    sel_t sel;

    always_comb begin
        sel = '0;
        if (active) begin
            case (region)
                RG_ROM:  sel.rom  = 1'b1;
                RG_PRAM: sel.pram = 1'b1;
                RG_DRAM: sel.dram = 1'b1;
                RG_LCD:  sel.lcd  = 1'b1;
                RG_KBD:  sel.kbd  = 1'b1;
                RG_DAC1: sel.dac1 = 1'b1;
                RG_DAC2: sel.dac2 = 1'b1;
                RG_LED:  sel.led  = 1'b1;
                default: sel = '0;
            endcase
        end
    end

    assign sel_n = ~sel;

    // R10: never two devices at once
    p_one_select_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~sel_n));

    // R10: all selects idle between accesses
    p_idle_no_select_r10: assert property (@(posedge clk) disable iff (rst)
        !active |-> (&sel_n));

endmodule

// File: rtl/bus_decode_ws.sv
module bus_decode_ws
    import memio_pkg::*;
#(
    parameter int ROM_WAITS    = 2,
    parameter int PRAM_WAITS   = 2,
    parameter int DRAM_WAITS   = 2,
    parameter int LCD_WAITS    = 6,
    parameter int PERIPH_WAITS = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        ps_n,
    input  logic        ds_n,
    input  logic        is_n,
    input  logic        rw,
    input  logic        strb_n,
    input  logic        user_mode,
    input  logic        remap_en,
    output logic [15:0] mem_addr,
    output logic        rom_cs_n,
    output logic        pram_cs_n,
    output logic        dram_cs_n,
    output logic        lcd_cs_n,
    output logic        kbd_cs_n,
    output logic        dac1_cs_n,
    output logic        dac2_cs_n,
    output logic        led_cs_n,
    output logic        mem_rd_n,
    output logic        mem_wr_n,
    output logic        io_rd_n,
    output logic        io_wr_n,
    output logic        ready,
    output logic        prot_err
);

    localparam int MAX_W = wmax(wmax(wmax(ROM_WAITS, PRAM_WAITS), wmax(DRAM_WAITS, LCD_WAITS)),
                                PERIPH_WAITS);
    localparam int CW    = $clog2(MAX_W + 2);

    logic          active;
    space_e        space;
    decode_t       dec;
    sel_t          sel_n;
    logic [CW-1:0] waits;
    logic          first_cycle;

    assign active = !strb_n;
    assign space  = pick_space(ps_n, ds_n, is_n);

    memio_space_decode u_decode (
        .clk(clk), .rst(rst), .space(space), .addr(addr), .rw(rw),
        .user_mode(user_mode), .remap_en(remap_en), .dec(dec)
    );

    always_comb begin
        case (dec.region)
            RG_ROM:  waits = CW'(ROM_WAITS);
            RG_PRAM: waits = CW'(PRAM_WAITS);
            RG_DRAM: waits = CW'(DRAM_WAITS);
            RG_LCD:  waits = CW'(LCD_WAITS);
            RG_KBD, RG_DAC1, RG_DAC2, RG_LED: waits = CW'(PERIPH_WAITS);
            default: waits = '0;
        endcase
    end

    memio_wait_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .active(active), .waits(waits),
        .ready(ready), .first_cycle(first_cycle)
    );

    memio_select_drive u_select (
        .clk(clk), .rst(rst), .active(active), .region(dec.region), .sel_n(sel_n)
    );

    assign rom_cs_n  = sel_n.rom;
    assign pram_cs_n = sel_n.pram;
    assign dram_cs_n = sel_n.dram;
    assign lcd_cs_n  = sel_n.lcd;
    assign kbd_cs_n  = sel_n.kbd;
    assign dac1_cs_n = sel_n.dac1;
    assign dac2_cs_n = sel_n.dac2;
    assign led_cs_n  = sel_n.led;
    assign mem_addr  = dec.maddr;

    assign mem_rd_n = !(active && (space == SP_PROG || space == SP_DATA) && rw);
    assign mem_wr_n = !(active && (space == SP_PROG || space == SP_DATA) && !rw);
    assign io_rd_n  = !(active && space == SP_IO && rw);
    assign io_wr_n  = !(active && space == SP_IO && !rw);

    assign prot_err = first_cycle && (dec.region == RG_PROT);

    // R3: protection flag is a single pulse
    p_prot_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        prot_err |=> !prot_err);

    // R3: a blocked write reaches no device
    p_prot_no_select_r3: assert property (@(posedge clk) disable iff (rst)
        prot_err |-> (&{rom_cs_n, pram_cs_n, dram_cs_n, lcd_cs_n, kbd_cs_n,
                        dac1_cs_n, dac2_cs_n, led_cs_n}));

    // R9: read and write enables never together
    p_enable_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_wr_n) && !(!io_rd_n && !io_wr_n));

endmodule

// File: tb/test_bus_decode_ws.sv
module test_bus_decode_ws;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        ps_n, ds_n, is_n, rw, strb_n, user_mode, remap_en;
    logic [15:0] mem_addr;
    logic        rom_cs_n, pram_cs_n, dram_cs_n, lcd_cs_n, kbd_cs_n;
    logic        dac1_cs_n, dac2_cs_n, led_cs_n;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, ready, prot_err;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    localparam int HOLD = 9;

    always #5 clk = ~clk;

    bus_decode_ws i_bus_decode_ws (
        .clk(clk), .rst(rst), .addr(addr), .ps_n(ps_n), .ds_n(ds_n), .is_n(is_n),
        .rw(rw), .strb_n(strb_n), .user_mode(user_mode), .remap_en(remap_en),
        .mem_addr(mem_addr), .rom_cs_n(rom_cs_n), .pram_cs_n(pram_cs_n),
        .dram_cs_n(dram_cs_n), .lcd_cs_n(lcd_cs_n), .kbd_cs_n(kbd_cs_n),
        .dac1_cs_n(dac1_cs_n), .dac2_cs_n(dac2_cs_n), .led_cs_n(led_cs_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .ready(ready), .prot_err(prot_err)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] sel_now();
        return ~{rom_cs_n, pram_cs_n, dram_cs_n, lcd_cs_n, kbd_cs_n,
                 dac1_cs_n, dac2_cs_n, led_cs_n};
    endfunction

    // sp: 0 no space strobe, 1 program, 2 data, 3 I/O, 4 program+data together
    task automatic model(input int sp, input logic [15:0] a, input logic r,
                         input logic u, input logic rm,
                         output logic [7:0] sel, output int w, output logic pe,
                         output logic [15:0] ma, output logic [3:0] en, output string req);
        sel = 8'h00; w = 0; pe = 1'b0; ma = a; en = 4'hF; req = "R10";
        if (sp == 1) begin
            en = r ? 4'b0111 : 4'b1011;
            if (rm && a < 16'h0040) begin
                sel = 8'h40; w = 2; ma = 16'hC000 + a; req = "R8";
            end else if (a >= 16'hC000) begin
                sel = 8'h40; w = 2; req = "R1";
            end else begin
                sel = 8'h80; w = 2; req = "R1";
            end
        end else if (sp == 2) begin
            en = r ? 4'b0111 : 4'b1011;
            req = "R2";
            if (a < 16'h8000) begin
                sel = 8'h00; w = 0;
            end else if (a < 16'h9000 && !r && u) begin
                pe = 1'b1; req = "R3";
            end else begin
                sel = 8'h20; w = 2;
            end
        end else if (sp == 3) begin
            en = r ? 4'b1101 : 4'b1110;
            req = "R5";
            if      (a == 16'h0000 && !r) begin sel = 8'h10; w = 6; req = "R4"; end
            else if (a == 16'h0001 &&  r) begin sel = 8'h10; w = 6; req = "R4"; end
            else if (a == 16'h0002 &&  r) begin sel = 8'h08; w = 1; req = "R4"; end
            else if (a == 16'h0004 && !r) begin sel = 8'h04; w = 1; req = "R4"; end
            else if (a == 16'h0005 && !r) begin sel = 8'h02; w = 1; req = "R4"; end
            else if (a == 16'h0006 && !r) begin sel = 8'h01; w = 1; req = "R4"; end
        end
    endtask

    task automatic access(input int sp, input logic [15:0] a, input logic r,
                          input logic u, input logic rm);
        logic [7:0]  esel;
        int          ew;
        logic        epe;
        logic [15:0] ema;
        logic [3:0]  een;
        string       req;
        int          first = -1;
        int          nready = 0;
        model(sp, a, r, u, rm, esel, ew, epe, ema, een, req);
        @(negedge clk);
        addr = a; rw = r; user_mode = u; remap_en = rm;
        ps_n = !(sp == 1 || sp == 4);
        ds_n = !(sp == 2 || sp == 4);
        is_n = !(sp == 3);
        strb_n = 1'b0;
        for (int c = 0; c < HOLD; c++) begin
            #1;
            if (c == 0) begin
                chk(req, "selects", sel_now(), esel);
                chk(req, "mem_addr", mem_addr, ema);
                chk("R9", "enables", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, een);
                chk("R3", "prot_err first cycle", prot_err, epe);
            end else if (c == 1) begin
                chk("R3", "prot_err second cycle", prot_err, 1'b0);
            end
            if (ready) begin
                nready++;
                if (first < 0) first = c;
            end
            @(negedge clk);
        end
        chk("R6", "ready cycle", first, ew);
        chk("R7", "ready pulses", nready, 1);
        strb_n = 1'b1; ps_n = 1'b1; ds_n = 1'b1; is_n = 1'b1;
        #1;
        chk("R7", "ready idle", ready, 1'b0);
        chk("R10", "selects idle", sel_now(), 8'h00);
    endtask

    initial begin
        logic [15:0] a;
        int sp;
        rst = 1'b1; addr = '0; ps_n = 1'b1; ds_n = 1'b1; is_n = 1'b1;
        rw = 1'b1; strb_n = 1'b1; user_mode = 1'b0; remap_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk("R11", "selects after reset", sel_now(), 8'h00);
        chk("R11", "enables after reset", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'hF);
        chk("R11", "ready/prot after reset", {ready, prot_err}, 2'b00);

        // R1 program map edges
        access(1, 16'hBFFF, 1, 0, 0);
        access(1, 16'hC000, 1, 0, 0);
        // R8 remap window and its edge
        access(1, 16'h0002, 1, 1, 1);
        access(1, 16'h003F, 1, 1, 1);
        access(1, 16'h0040, 1, 1, 1);
        access(1, 16'h0002, 1, 1, 0);
        // R2 data map
        access(2, 16'h7FFF, 1, 1, 0);
        access(2, 16'h9000, 0, 1, 0);
        // R3 monitor window
        access(2, 16'h8FFF, 0, 1, 0);
        access(2, 16'h8000, 1, 1, 0);
        access(2, 16'h8800, 0, 0, 0);
        // R4 I/O map, R5 wrong direction and unmapped
        access(3, 16'h0000, 0, 0, 0);
        access(3, 16'h0001, 1, 0, 0);
        access(3, 16'h0002, 1, 0, 0);
        access(3, 16'h0004, 0, 0, 0);
        access(3, 16'h0005, 0, 0, 0);
        access(3, 16'h0006, 0, 0, 0);
        access(3, 16'h0006, 1, 0, 0);
        access(3, 16'h0003, 0, 0, 0);
        access(3, 16'h0100, 0, 0, 0);
        // R10 conflicting and missing space strobes
        access(4, 16'hC000, 1, 0, 0);
        access(0, 16'hC000, 1, 0, 0);

        void'($urandom(32'd20240517));
        for (int n = 0; n < 300; n++) begin
            sp = 1 + int'($urandom % 3);
            if ($urandom % 20 == 0) sp = 4;
            case ($urandom % 8)
                0: a = 16'($urandom);
                1: a = 16'h0030 + 16'($urandom % 32);
                2: a = 16'h7FF8 + 16'($urandom % 16);
                3: a = 16'h8FF8 + 16'($urandom % 16);
                4: a = 16'($urandom % 8);
                5: a = 16'hBFF8 + 16'($urandom % 16);
                6: a = 16'h8000 + 16'($urandom % 16'h1000);
                default: a = 16'($urandom % 8);
            endcase
            access(sp, a, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule